// File: doc/BRIEF.md
# I2C High-Speed Mode Tracker

This block watches a shared two-wire bus without ever driving it. It samples the clock and data lines with a fast system clock and passes each line through a synchroniser. From the synchronised lines it finds start, repeated-start and stop conditions. It also frames the first byte sent after each start condition.

The block keeps track of the bus speed mode. A first byte of the form `00001xxx` is a reserved master code. When that byte is followed by a ninth bit left high (not acknowledged), the tracker enters high-speed mode. The mode stays set through any number of repeated starts, and only a stop condition clears it. A master code is never reported as a slave address. If a master code is acknowledged, the block raises a protocol-error pulse and stays in fast/standard mode.

Other logic on the chip uses the mode flag, the condition pulses and the captured address byte. With them it can follow which speed regime and which target the bus is addressing.

Top module: `hsm_bus_watch`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `hs_mode`, `start_p`, `rstart_p`, `stop_p`, `addr_valid` and `proto_err` are all 0.
- R2: A START condition is a falling edge of data while clock is high on an idle bus. It gives one cycle of `start_p`.
- R3: A start condition that arrives while a transfer is open (after a START and before a STOP) gives `rstart_p` and no `start_p`.
- R4: A STOP condition is a rising edge of data while clock is high. It gives one cycle of `stop_p` and returns the bus to idle.
- R5: The first byte after any start or repeated start is shifted in MSB first on the rising clock edges. If it is not a master code, `addr_valid` pulses once and `addr_byte` holds that byte. Later bytes of the same transfer are not captured.
- R6: A first byte whose upper five bits are `00001` is a master code. It never produces `addr_valid`, in either mode.
- R7: A master code received in fast/standard mode, followed by a ninth bit sampled high, sets `hs_mode`.
- R8: A master code received in fast/standard mode, followed by a ninth bit sampled low, gives one cycle of `proto_err`, and `hs_mode` stays 0.
- R9: While `hs_mode` is 1, repeated starts leave it at 1. Address bytes after each repeated start are still captured under R5.
- R10: `hs_mode` falls only after a STOP condition.
- R11: `start_p`, `rstart_p` and `stop_p` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, several times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| hs_mode | output | 1 | 1 while the bus is in high-speed mode |
| start_p | output | 1 | One-cycle pulse on a START condition |
| rstart_p | output | 1 | One-cycle pulse on a repeated START condition |
| stop_p | output | 1 | One-cycle pulse on a STOP condition |
| addr_valid | output | 1 | One-cycle pulse when a slave address byte has been framed |
| addr_byte | output | 8 | Last framed address byte (address and R/W bit) |
| proto_err | output | 1 | One-cycle pulse when a master code is acknowledged |

## Verification
A line change driven before clock edge k reaches the synchroniser output at edge k+1. The condition pulses and the framed-byte strobe are registered at edge k+2. `addr_valid`, `proto_err` and any change of `hs_mode` follow at edge k+3. The bench drives the lines on falling clock edges and holds every bus phase for at least four clocks. It counts pulses with a falling-edge monitor, so pulse timing does not depend on when a phase is checked. It compares counts, the captured byte and the mode flag only at the end of a byte or condition, which is well past the three-cycle latency.

// File: rtl/hsm_pkg.sv
package hsm_pkg;

    localparam int BYTE_BITS = 8;
    localparam logic [4:0] MCODE_PREFIX = 5'b00001;

    typedef enum logic [1:0] {
        MODE_FS    = 2'd0,
        MODE_MCODE = 2'd1,
        MODE_HS    = 2'd2
    } speed_mode_e;

    typedef struct packed {
        logic start;
        logic rstart;
        logic stop;
    } bus_cond_t;

    function automatic logic is_master_code(input logic [BYTE_BITS-1:0] b);
        return b[BYTE_BITS-1 -: 5] == MCODE_PREFIX;
    endfunction

endpackage

// File: rtl/hsm_line_sync.sv
module hsm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic level,
    output logic prev
);
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-1:0], line_in};
    end

    assign level = chain[STAGES-1];
    assign prev  = chain[STAGES];
endmodule

// File: rtl/hsm_cond_detect.sv
module hsm_cond_detect
    import hsm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_lvl,
    input  logic      scl_prev,
    input  logic      sda_lvl,
    input  logic      sda_prev,
    output bus_cond_t cond,
    output logic      busy
);
    logic scl_steady_hi;
    logic sda_fell;
    logic sda_rose;

    assign scl_steady_hi = scl_lvl & scl_prev;
    assign sda_fell      = ~sda_lvl & sda_prev;
    assign sda_rose      = sda_lvl & ~sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cond <= '0;
            busy <= 1'b0;
        end else begin
            cond.start  <= scl_steady_hi & sda_fell & ~busy;
            cond.rstart <= scl_steady_hi & sda_fell & busy;
            cond.stop   <= scl_steady_hi & sda_rose;
            if (scl_steady_hi & sda_fell)      busy <= 1'b1;
            else if (scl_steady_hi & sda_rose) busy <= 1'b0;
        end
    end

    p_one_cond_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cond.start, cond.rstart, cond.stop}));
    p_rstart_open_r3: assert property (@(posedge clk) disable iff (rst)
        cond.rstart |-> busy);
    p_stop_idle_r4: assert property (@(posedge clk) disable iff (rst)
        cond.stop |-> !busy);
endmodule

// File: rtl/hsm_byte_framer.sv
module hsm_byte_framer #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            scl_rise,
    input  logic            sda_lvl,
    input  logic            restart,
    input  logic            busy,
    output logic            byte_done,
    output logic [BITS-1:0] byte_val,
    output logic            ack_evt,
    output logic            ack_nack
);
    localparam int CNT_W = $clog2(BITS + 1);
    localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BITS - 1);
    localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BITS);

    logic [CNT_W-1:0] cnt;
    logic [BITS-1:0]  shreg;
    logic             first;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0; shreg <= '0; first <= 1'b0;
            byte_done <= 1'b0; byte_val <= '0;
            ack_evt <= 1'b0; ack_nack <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            ack_evt   <= 1'b0;
            if (restart) begin
                cnt   <= '0;
                first <= 1'b1;
            end else if (scl_rise && busy) begin
                if (cnt == ACK_SLOT) begin
                    cnt   <= '0;
                    first <= 1'b0;
                    if (first) begin
                        ack_evt  <= 1'b1;
                        ack_nack <= sda_lvl;
                    end
                end else begin
                    cnt   <= cnt + 1'b1;
                    shreg <= {shreg[BITS-2:0], sda_lvl};
                    if (first && cnt == LAST_DATA) begin
                        byte_done <= 1'b1;
                        byte_val  <= {shreg[BITS-2:0], sda_lvl};
                    end
                end
            end
        end
    end

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= ACK_SLOT);
    p_done_ack_apart_r5: assert property (@(posedge clk) disable iff (rst)
        !(byte_done && ack_evt));
endmodule

// File: rtl/hsm_mode_ctrl.sv
module hsm_mode_ctrl
    import hsm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 byte_done,
    input  logic [BYTE_BITS-1:0] byte_val,
    input  logic                 ack_evt,
    input  logic                 ack_nack,
    input  logic                 restart,
    input  logic                 stop,
    output logic                 hs_mode,
    output logic                 proto_err,
    output logic                 addr_valid,
    output logic [BYTE_BITS-1:0] addr_byte
);
    speed_mode_e mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode       <= MODE_FS;
            proto_err  <= 1'b0;
            addr_valid <= 1'b0;
            addr_byte  <= '0;
        end else begin
            proto_err  <= 1'b0;
            addr_valid <= 1'b0;
            if (stop) begin
                mode <= MODE_FS;
            end else begin
                if (restart && mode == MODE_MCODE) mode <= MODE_FS;
                if (byte_done) begin
                    if (is_master_code(byte_val)) begin
                        if (mode == MODE_FS) mode <= MODE_MCODE;
                    end else begin
                        addr_valid <= 1'b1;
                        addr_byte  <= byte_val;
                    end
                end
                if (ack_evt && mode == MODE_MCODE) begin
                    if (ack_nack) begin
                        mode <= MODE_HS;
                    end else begin
                        mode      <= MODE_FS;
                        proto_err <= 1'b1;
                    end
                end
            end
        end
    end

    assign hs_mode = (mode == MODE_HS);

    p_no_mcode_addr_r6: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> !is_master_code(addr_byte));
    p_hs_entry_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(hs_mode) |-> $past(ack_evt && ack_nack));
    p_err_fs_r8: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> !hs_mode);
    p_hs_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (restart && hs_mode) |=> hs_mode);
    p_hs_exit_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(hs_mode) |-> $past(stop));
endmodule

// File: rtl/hsm_bus_watch.sv
module hsm_bus_watch
    import hsm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 hs_mode,
    output logic                 start_p,
    output logic                 rstart_p,
    output logic                 stop_p,
    output logic                 addr_valid,
    output logic [BYTE_BITS-1:0] addr_byte,
    output logic                 proto_err
);
    logic scl_lvl, scl_prev, sda_lvl, sda_prev;
    bus_cond_t cond;
    logic busy;
    logic byte_done, ack_evt, ack_nack;
    logic [BYTE_BITS-1:0] byte_val;
    logic restart;

    hsm_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_in(scl_i), .level(scl_lvl), .prev(scl_prev));
    hsm_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_in(sda_i), .level(sda_lvl), .prev(sda_prev));

    hsm_cond_detect u_cond (
        .clk(clk), .rst(rst),
        .scl_lvl(scl_lvl), .scl_prev(scl_prev),
        .sda_lvl(sda_lvl), .sda_prev(sda_prev),
        .cond(cond), .busy(busy));

    assign restart = cond.start | cond.rstart;

    hsm_byte_framer #(.BITS(BYTE_BITS)) u_framer (
        .clk(clk), .rst(rst),
        .scl_rise(scl_lvl & ~scl_prev), .sda_lvl(sda_lvl),
        .restart(restart), .busy(busy),
        .byte_done(byte_done), .byte_val(byte_val),
        .ack_evt(ack_evt), .ack_nack(ack_nack));

    hsm_mode_ctrl u_mode (
        .clk(clk), .rst(rst),
        .byte_done(byte_done), .byte_val(byte_val),
        .ack_evt(ack_evt), .ack_nack(ack_nack),
        .restart(restart), .stop(cond.stop),
        .hs_mode(hs_mode), .proto_err(proto_err),
        .addr_valid(addr_valid), .addr_byte(addr_byte));

    assign start_p  = cond.start;
    assign rstart_p = cond.rstart;
    assign stop_p   = cond.stop;

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> !(hs_mode || start_p || rstart_p || stop_p || addr_valid || proto_err));
    p_start_idle_r2: assert property (@(posedge clk) disable iff (rst)
        start_p |-> !$past(busy));
endmodule

// File: tb/sim_hsm_bus_watch.sv
`timescale 1ns/1ps
module sim_hsm_bus_watch;
    localparam int Q = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic hs_mode, start_p, rstart_p, stop_p, addr_valid, proto_err;
    logic [7:0] addr_byte;

    always #2.5 clk = ~clk;

    hsm_bus_watch u0 (
        .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda),
        .hs_mode(hs_mode), .start_p(start_p), .rstart_p(rstart_p),
        .stop_p(stop_p), .addr_valid(addr_valid), .addr_byte(addr_byte),
        .proto_err(proto_err));

    int n_start = 0, n_rstart = 0, n_stop = 0, n_av = 0, n_err = 0, n_overlap = 0;
    int e_start = 0, e_rstart = 0, e_stop = 0, e_av = 0, e_err = 0;
    logic [7:0] e_addr = 8'h00;
    bit e_hs = 1'b0;
    int checks = 0, fails = 0;

    always @(negedge clk) begin
        if (!rst) begin
            n_start  += int'(start_p);
            n_rstart += int'(rstart_p);
            n_stop   += int'(stop_p);
            n_av     += int'(addr_valid);
            n_err    += int'(proto_err);
            if (int'(start_p) + int'(rstart_p) + int'(stop_p) > 1) n_overlap++;
        end
    end

    function automatic bit mc(input logic [7:0] b);
        return (b & 8'hF8) == 8'h08;
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start(input bit repeated);
        if (repeated) begin
            scl = 1'b0; tick(Q); sda = 1'b1; tick(Q);
        end
        scl = 1'b1; tick(Q);
        sda = 1'b0; tick(Q);
        scl = 1'b0; tick(Q);
        if (repeated) e_rstart++; else e_start++;
    endtask

    task automatic do_stop();
        scl = 1'b0; sda = 1'b0; tick(Q);
        scl = 1'b1; tick(Q);
        sda = 1'b1; tick(2*Q);
        e_stop++;
        e_hs = 1'b0;
    endtask

    task automatic do_bit(input logic v);
        scl = 1'b0; sda = v; tick(Q);
        scl = 1'b1; tick(2*Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic do_byte(input logic [7:0] b, input logic ninth, input bit first);
        for (int i = 7; i >= 0; i--) do_bit(b[i]);
        do_bit(ninth);
        tick(Q);
        if (first) begin
            if (mc(b)) begin
                if (!e_hs) begin
                    if (ninth) e_hs = 1'b1; else e_err++;
                end
            end else begin
                e_av++;
                e_addr = b;
            end
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R2 start count"}, n_start, e_start);
        chk({tag, " R3 rstart count"}, n_rstart, e_rstart);
        chk({tag, " R4 stop count"}, n_stop, e_stop);
        chk({tag, " R5 addr count"}, n_av, e_av);
        chk({tag, " R5 addr byte"}, int'(addr_byte), int'(e_addr));
        chk({tag, " R8 err count"}, n_err, e_err);
        chk({tag, " R7 R10 hs_mode"}, int'(hs_mode), int'(e_hs));
        chk({tag, " R11 overlap"}, n_overlap, 0);
    endtask

    initial begin : watchdog
        #(180000 * 5);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] b;
        int unsigned seed;
        seed = 32'd1337;
        void'($urandom(seed));
        tick(5);
        chk("R1 hs_mode in reset", int'(hs_mode), 0);
        chk("R1 pulses in reset", int'(start_p | rstart_p | stop_p | addr_valid | proto_err), 0);
        rst = 1'b0;
        tick(4);
        chk("R1 after reset", int'(hs_mode | start_p | proto_err | addr_valid), 0);

        // R2 R4 R5: plain address plus data byte that must not be captured
        do_start(1'b0);
        do_byte(8'hA4, 1'b0, 1'b1);
        do_byte(8'h5A, 1'b0, 1'b0);
        check_all("dir1");
        do_stop();
        check_all("dir1 stop");

        // R7 R9 R6 R10: master code, chained transfers in high-speed mode
        do_start(1'b0);
        do_byte(8'h0D, 1'b1, 1'b1);
        check_all("dir2 R7 mcode");
        do_start(1'b1);
        check_all("dir2 R9 after Sr");
        do_byte(8'h3C, 1'b0, 1'b1);
        check_all("dir2 R9 addr");
        do_start(1'b1);
        do_byte(8'h08, 1'b1, 1'b1);
        check_all("dir2 R6 mcode in hs");
        do_stop();
        check_all("dir2 R10 stop");

        // R8: master code acknowledged
        do_start(1'b0);
        do_byte(8'h0F, 1'b0, 1'b1);
        check_all("dir3 R8");
        do_stop();

        // random transfers
        for (int t = 0; t < 40; t++) begin
            int nsr;
            do_start(1'b0);
            nsr = int'($urandom_range(0, 2));
            for (int s = 0; s <= nsr; s++) begin
                if (s > 0) do_start(1'b1);
                b = 8'($urandom);
                if ($urandom_range(0, 3) == 0) b = {5'b00001, b[2:0]};
                do_byte(b, 1'($urandom), 1'b1);
                if ($urandom_range(0, 1) == 1) do_byte(8'($urandom), 1'($urandom), 1'b0);
                check_all("rand");
            end
            do_stop();
            check_all("rand stop R10");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule